// File: doc/BRIEF.md
# Logical Right and Funnel Shifter

A purely combinational shift unit for the execute stage of a 32-bit processor. It right-shifts a data word logically, by an amount taken either from a register operand or from a 5-bit immediate. It also performs a funnel shift: two registers are joined into a 64-bit value and shifted right, and the low word of the shifted value is kept.

Alongside the 32-bit result, the unit reports which destination register the decoder should write. The low-operand register is the destination for plain shifts, and the high-operand register for the funnel shift. It also reports whether the condition flags are to be written, together with carry, overflow, sign and zero values. Register file access, decode and pipeline control are outside the block.

The operation code is `op`: 0 shifts by register, 1 shifts by immediate, 2 is the funnel shift and 3 passes the operand through. The shifter core can be built as a logarithmic stage chain or as a single shift operator, chosen by a parameter.

Top module: `shf_unit`

## Requirements
- R1: With `op`=0, `result` equals `src_lo` shifted right by `amt_reg[4:0]`; bits 31..5 of `amt_reg` have no effect.
- R2: In both logical forms (`op`=0 and `op`=1), the `n` most significant bits of `result` are zero for a shift amount `n`.
- R3: With `op`=1, `result` equals `src_lo` shifted right by `imm`, zero-extended.
- R4: With `op`=2, `result` equals bits 31..0 of the 64-bit value {`src_hi`,`src_lo`} shifted right by `amt_reg[4:0]`.
- R5: `dest_hi` is 1 exactly when `op`=2; it is 0 for every other code.
- R6: With `op`=0 or `op`=1, `flag_upd` is 1 and `flag_ov` is 0.
- R7: With `op`=0 or `op`=1 and a shift amount `n`, `flag_cy` equals `src_lo[n-1]` for `n`>0 and is 0 for `n`=0.
- R8: With `op`=0 or `op`=1, `flag_s` equals `result[31]` and `flag_z` is 1 exactly when `result` is all zeros.
- R9: With `op`=2 or `op`=3, `flag_upd` is 0 and all four flag outputs are 0.
- R10: A shift amount of zero yields `result` equal to `src_lo` in every form.
- R11: With `op`=3, `result` equals `src_lo` and `dest_hi` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 2 | Operation: 0 shift by register, 1 shift by immediate, 2 funnel, 3 pass |
| amt_reg | input | 32 | Register holding the shift amount (low five bits used) |
| src_lo | input | 32 | Data word; low half of the funnel pair |
| src_hi | input | 32 | High half of the funnel pair |
| imm | input | 5 | Immediate shift amount |
| result | output | 32 | Shifted word |
| dest_hi | output | 1 | 1: write the high-operand register, 0: write the low-operand register |
| flag_upd | output | 1 | Flags are to be written |
| flag_cy | output | 1 | Carry: last bit shifted out of bit 0 |
| flag_ov | output | 1 | Overflow (always 0 when written) |
| flag_s | output | 1 | Sign: result bit 31 |
| flag_z | output | 1 | Zero: result is all zeros |

## Verification
Random operands with random amounts cover every op code. Directed cases then pin the amounts 0, 1, 31 and a register amount whose upper bits are set. Walking a single one bit through `src_lo` shows whether carry picks the right bit. Giving `src_hi` a pattern unlike `src_lo` shows whether the funnel mixes in the high half while the logical forms fill with zeros. Shifting a lone low bit out produces a zero result with carry set, so a zero flag derived from the wrong quantity is exposed.

// File: rtl/shf_pkg.sv
package shf_pkg;
   typedef enum logic [1:0] {
      SHF_OP_SHR_REG = 2'd0,
      SHF_OP_SHR_IMM = 2'd1,
      SHF_OP_FUNNEL  = 2'd2,
      SHF_OP_PASS    = 2'd3
   } shf_op_e;

   typedef struct packed {
      logic cy;
      logic ov;
      logic s;
      logic z;
   } shf_flags_t;
endpackage

// File: rtl/shf_amt_sel.sv
module shf_amt_sel #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = $clog2(DATA_W)
) (
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] amt_reg,
   input  logic [AMT_W-1:0]  imm,
   output logic [AMT_W-1:0]  amt,
   output logic              use_hi,
   output logic              logical
);
   import shf_pkg::*;

   logic unused_amt_hi;
   assign unused_amt_hi = ^amt_reg[DATA_W-1:AMT_W];

   always_comb begin
      amt     = '0;
      use_hi  = 1'b0;
      logical = 1'b0;
      unique case (shf_op_e'(op))
         SHF_OP_SHR_REG: begin
            amt     = amt_reg[AMT_W-1:0];
            logical = 1'b1;
         end
         SHF_OP_SHR_IMM: begin
            amt     = imm;
            logical = 1'b1;
         end
         SHF_OP_FUNNEL: begin
            amt    = amt_reg[AMT_W-1:0];
            use_hi = 1'b1;
         end
         default: amt = '0;
      endcase
   end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = $clog2(DATA_W),
   parameter int ARCH   = 0
) (
   input  logic [DATA_W-1:0] hi,
   input  logic [DATA_W-1:0] lo,
   input  logic [AMT_W-1:0]  amt,
   output logic [DATA_W-1:0] res,
   output logic              cy
);
   localparam int WIDE = 2 * DATA_W + 1;

   logic [WIDE-1:0] start;
   logic [WIDE-1:0] fin;
   logic unused_top;

   // Guard bit below bit 0 catches the last bit shifted out.
   assign start = {hi, lo, 1'b0};

   generate
      if (ARCH == 0) begin : g_log
         logic [WIDE-1:0] stg [0:AMT_W];
         assign stg[0] = start;
         for (genvar i = 0; i < AMT_W; i++) begin : g_stage
            localparam int SH = 1 << i;
            assign stg[i+1] = amt[i] ? (stg[i] >> SH) : stg[i];
         end
         assign fin = stg[AMT_W];
      end else if (ARCH == 1) begin : g_flat
         assign fin = start >> amt;
      end else begin : g_bad
         $error("shf_barrel: ARCH must be 0 or 1");
      end
   endgenerate

   assign res        = fin[DATA_W:1];
   assign cy         = fin[0];
   assign unused_top = ^fin[WIDE-1:DATA_W+1];
endmodule

// File: rtl/shf_flag_gen.sv
module shf_flag_gen #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] res,
   input  logic              cy_in,
   input  logic              upd,
   output shf_pkg::shf_flags_t flags
);
   always_comb begin
      flags = '0;
      if (upd) begin
         flags.cy = cy_in;
         flags.ov = 1'b0;
         flags.s  = res[DATA_W-1];
         flags.z  = (res == '0);
      end
   end
endmodule

// File: rtl/shf_unit.sv
module shf_unit #(
   parameter int DATA_W = 32,
   parameter int ARCH   = 0,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] amt_reg,
   input  logic [DATA_W-1:0] src_lo,
   input  logic [DATA_W-1:0] src_hi,
   input  logic [AMT_W-1:0]  imm,
   output logic [DATA_W-1:0] result,
   output logic              dest_hi,
   output logic              flag_upd,
   output logic              flag_cy,
   output logic              flag_ov,
   output logic              flag_s,
   output logic              flag_z
);
   import shf_pkg::*;

   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_chk_w
         $error("shf_unit: DATA_W must be a power of two >= 2");
      end
   endgenerate

   logic [AMT_W-1:0]  amt;
   logic              use_hi;
   logic              logical;
   logic [DATA_W-1:0] hi_sel;
   logic              cy_raw;
   shf_flags_t        flags;

   shf_amt_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amt (
      .op      (op),
      .amt_reg (amt_reg),
      .imm     (imm),
      .amt     (amt),
      .use_hi  (use_hi),
      .logical (logical)
   );

   assign hi_sel = use_hi ? src_hi : '0;

   shf_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W), .ARCH(ARCH)) u_bar (
      .hi  (hi_sel),
      .lo  (src_lo),
      .amt (amt),
      .res (result),
      .cy  (cy_raw)
   );

   shf_flag_gen #(.DATA_W(DATA_W)) u_flg (
      .res   (result),
      .cy_in (cy_raw),
      .upd   (logical),
      .flags (flags)
   );

   assign dest_hi  = use_hi;
   assign flag_upd = logical;
   assign flag_cy  = flags.cy;
   assign flag_ov  = flags.ov;
   assign flag_s   = flags.s;
   assign flag_z   = flags.z;
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input logic [1:0]        op,
   input logic [DATA_W-1:0] amt_reg,
   input logic [DATA_W-1:0] src_lo,
   input logic [DATA_W-1:0] src_hi,
   input logic [AMT_W-1:0]  imm,
   input logic [DATA_W-1:0] result,
   input logic              dest_hi,
   input logic              flag_upd,
   input logic              flag_cy,
   input logic              flag_ov,
   input logic              flag_s,
   input logic              flag_z
);
   logic [AMT_W-1:0] n;
   logic             is_log;
   logic unused_chk;
   assign unused_chk = ^{src_hi, amt_reg[DATA_W-1:AMT_W]};

   assign is_log = (op == 2'd0) || (op == 2'd1);
   assign n      = (op == 2'd1) ? imm : amt_reg[AMT_W-1:0];

   always_comb begin
      AST_NO_OVERFLOW: assert (!(is_log && flag_ov)) else $error("ov set on logical shift"); // R6
      AST_FLAG_WRITE: assert (flag_upd == is_log) else $error("flag_upd wrong"); // R6
      AST_DEST_SEL: assert (dest_hi == (op == 2'd2)) else $error("dest_hi wrong"); // R5
      AST_FLAGS_QUIET: assert (is_log || !(flag_cy || flag_ov || flag_s || flag_z)) else $error("flags active"); // R9
      AST_SIGN_FLAG: assert (!is_log || flag_s == result[DATA_W-1]) else $error("sign flag wrong"); // R8
      AST_ZERO_FLAG: assert (!is_log || flag_z == (result == '0)) else $error("zero flag wrong"); // R8
      AST_ZERO_AMT: assert (!(op != 2'd3 && n == '0) || result == src_lo) else $error("zero amount changed data"); // R10
      AST_PASS_THRU: assert (op != 2'd3 || result == src_lo) else $error("pass changed data"); // R11
      AST_ZERO_CARRY: assert (!(is_log && n == '0) || !flag_cy) else $error("carry on zero amount"); // R7
      AST_MSB_FILL: assert (!(is_log && n != '0) || !result[DATA_W-1]) else $error("msb not zero-filled"); // R2
   end
endmodule

bind shf_unit shf_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/shf_unit_test.sv
module shf_unit_test;
   logic        clk = 1'b0;
   logic [1:0]  op;
   logic [31:0] amt_reg, src_lo, src_hi;
   logic [4:0]  imm;
   logic [31:0] result;
   logic        dest_hi, flag_upd, flag_cy, flag_ov, flag_s, flag_z;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   shf_unit uut (
      .op(op), .amt_reg(amt_reg), .src_lo(src_lo), .src_hi(src_hi), .imm(imm),
      .result(result), .dest_hi(dest_hi), .flag_upd(flag_upd),
      .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_s(flag_s), .flag_z(flag_z)
   );

   function automatic int ref_amt(input logic [1:0] o, input logic [31:0] a, input logic [4:0] i);
      if (o == 2'd1) return int'(i);
      if (o == 2'd3) return 0;
      return int'(a % 32);
   endfunction

   // Bit-serial reference: move one bit at a time, remember the last bit lost.
   function automatic logic [32:0] ref_shift(input logic [1:0] o, input int n,
                                             input logic [31:0] lo, input logic [31:0] hi);
      logic [63:0] v = {(o == 2'd2) ? hi : 32'd0, lo};
      logic        c = 1'b0;
      for (int k = 0; k < n; k++) begin
         c = v[0];
         v = {1'b0, v[63:1]};
      end
      return {c, v[31:0]};
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic apply(input logic [1:0] o, input logic [31:0] a, input logic [31:0] lo,
                        input logic [31:0] hi, input logic [4:0] i);
      int          n;
      logic [32:0] r;
      logic        lg;
      @(posedge clk);
      op = o; amt_reg = a; src_lo = lo; src_hi = hi; imm = i;
      @(negedge clk);
      n  = ref_amt(o, a, i);
      r  = ref_shift(o, n, lo, hi);
      lg = (o == 2'd0) || (o == 2'd1);
      case (o)
         2'd0: check("R1 result", result, r[31:0]);
         2'd1: check("R3 result", result, r[31:0]);
         2'd2: check("R4 result", result, r[31:0]);
         default: check("R11 result", result, lo);
      endcase
      check("R5 dest_hi", 32'(dest_hi), 32'(o == 2'd2));
      if (n == 0) check("R10 zero amount", result, lo);
      if (lg) begin
         if (n > 0) check("R2 zero fill", result >> (32 - n), 32'd0);
         check("R6 flag_upd", 32'(flag_upd), 32'd1);
         check("R6 flag_ov", 32'(flag_ov), 32'd0);
         check("R7 flag_cy", 32'(flag_cy), 32'(r[32]));
         check("R8 flag_s", 32'(flag_s), 32'(r[31]));
         check("R8 flag_z", 32'(flag_z), 32'(r[31:0] == 32'd0));
      end else begin
         check("R9 flags quiet", {28'd0, flag_upd, flag_cy, flag_ov, flag_s | flag_z},
               32'd0);
      end
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5A17);
      op = 2'd0; amt_reg = '0; src_lo = '0; src_hi = '0; imm = '0;
      @(negedge clk);
      // Idle state: all-zero inputs give a zero result with the zero flag set.
      check("R8 idle result", result, 32'd0);
      check("R8 idle zero flag", 32'(flag_z), 32'd1);

      // Directed corners
      apply(2'd0, 32'hFFFF_FFE3, 32'h8000_0001, 32'h1234_5678, 5'd0);  // R1 upper amount bits ignored
      apply(2'd0, 32'h0000_0020, 32'hDEAD_BEEF, 32'h0, 5'd7);          // R10 low bits zero
      apply(2'd1, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31);         // R2 max fill
      apply(2'd1, 32'h0, 32'h0000_0001, 32'h0, 5'd1);                  // R7 carry, zero result
      apply(2'd1, 32'h0, 32'hCAFE_F00D, 32'h0, 5'd0);                  // R10 imm zero
      apply(2'd2, 32'd0, 32'h0123_4567, 32'h89AB_CDEF, 5'd3);          // R4 amount zero
      apply(2'd2, 32'd31, 32'h0, 32'hFFFF_FFFF, 5'd0);                 // R4 max
      apply(2'd2, 32'd16, 32'hAAAA_5555, 32'h1357_9BDF, 5'd0);         // R4 half
      apply(2'd3, 32'd9, 32'h7654_3210, 32'hFFFF_FFFF, 5'd9);          // R11
      for (int b = 0; b < 32; b++) begin
         apply(2'd0, 32'(b + 1), 32'd1 << b, 32'hFFFF_FFFF, 5'd0);   // R7 walking carry
         apply(2'd1, 32'h0, 32'd1 << b, 32'h0, 5'(b));
      end

      // Constrained random
      for (int k = 0; k < 1500; k++) begin
         logic [31:0] a;
         a = $urandom();
         if (k % 4 == 0) a = a & 32'h1F;
         apply(2'($urandom() % 4), a, $urandom(), $urandom(), 5'($urandom()));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule